// File: doc/BRIEF.md
# Display controller bring-up and park supervisor

This block sits on the host side of a display controller and sequences it through power-up and power-down. It owns the controller's active-low reset. It watches one status line from the controller whose meaning changes with the phase. While the controller auto-initializes, the line is a busy level. Once initialization is over, a short high pulse on the same line is an error interrupt. The block holds host serial traffic off through a ready output until initialization has finished and a guard gap has passed.

The block also handles a power-good early warning. While the warning is present, and for a hold time after it goes away, the controller stays out of reset so that it can park its mirror array. Only after that hold does the block assert reset again.

All time limits are computed from a `CLK_HZ` parameter. The status and warning inputs each pass through a two-flop synchronizer. The controller is driven by a state machine with the following states:

- `ST_RESET_HELD`: reset asserted, waiting for a power-up request.
- `ST_WAIT_BUSY_HI`: reset released, waiting for the busy level to appear.
- `ST_WAIT_BUSY_LO`: waiting for the busy level to clear.
- `ST_GUARD`: the guard gap before host traffic.
- `ST_READY`: host traffic allowed, error pulses monitored.
- `ST_PARKING`: park in progress.
- `ST_FAULT`: reset asserted after a timeout.

The transitions are:

- **start**: `ST_RESET_HELD` or `ST_FAULT` to `ST_WAIT_BUSY_HI`.
- **busy seen**: `ST_WAIT_BUSY_HI` to `ST_WAIT_BUSY_LO`.
- **start timeout**: `ST_WAIT_BUSY_HI` to `ST_FAULT`.
- **busy cleared**: `ST_WAIT_BUSY_LO` to `ST_GUARD`.
- **init timeout**: `ST_WAIT_BUSY_LO` to `ST_FAULT`.
- **gap elapsed**: `ST_GUARD` to `ST_READY`.
- **park**: any of the four init/ready states to `ST_PARKING`.
- **hold elapsed**: `ST_PARKING` to `ST_RESET_HELD`.

Top module: `ctrl_bringup_supervisor`

## Requirements
- R1: After `rst_n`, the outputs are `ctl_rst_n`=0, `host_ready`=0 and all three flags 0, and they stay that way with no request. A `start_req` high at a clock edge, in `ST_RESET_HELD` or `ST_FAULT` with no synchronized park warning, releases `ctl_rst_n` right after that edge.
- R2: The synchronized status must be seen high within `START_US` (5 ms) of reset release. If it is not, `start_timeout` is set, the block enters `ST_FAULT` and `ctl_rst_n` returns to 0.
- R3: With `motor_en`=0, the synchronized status must be seen low within `INIT_US` (100 ms), counted from reset release. If it is not, `init_timeout` is set and the block enters `ST_FAULT` with `ctl_rst_n`=0.
- R4: With `motor_en`=1, the limit of R3 is replaced by `LONG_INIT_MS` (several seconds).
- R5: `host_ready` rises exactly `GUARD_US` (3 ms) plus one cycle after the synchronized busy level falls. It is never high while `ctl_rst_n` is low.
- R6: In `ST_READY`, a status pulse that is high for at least two synchronized cycles sets `err_flag`, and a one-cycle pulse does not. `err_flag` stays set until the next accepted `start_req` clears it.
- R7: Status activity before `ST_READY` (the busy level, or pulses during the guard gap) never sets `err_flag`.
- R8: A park warning in `ST_READY` drops `host_ready` three cycles after it is applied. `ctl_rst_n` stays high while the warning lasts and for `HOLD_US` (500 us) after it ends. It then goes low three cycles plus the hold after the warning falls.
- R9: A park warning during initialization abandons it at once: no timeout flag is raised while parked, and the same release hold then applies.
- R10: `ST_FAULT` keeps `ctl_rst_n` low and the flags set. It ignores the park warning and any `start_req` made while the warning is present. Only an accepted `start_req` leaves it, and that also clears the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start_req | input | 1 | Power-up request, sampled each edge |
| motor_en | input | 1 | Selects the long initialization limit |
| park_warn | input | 1 | Power-good early warning, asynchronous, active high |
| ctl_status | input | 1 | Controller busy/interrupt line, asynchronous |
| ctl_rst_n | output | 1 | Active-low reset to the controller |
| host_ready | output | 1 | High when host serial traffic may start |
| start_timeout | output | 1 | Busy level never appeared in time |
| init_timeout | output | 1 | Busy level did not clear in time |
| err_flag | output | 1 | Latched error interrupt |

## Verification
The hardest cases to reach from the ports are the exact limits of the timeout windows. Whether a deadline is met depends on the synchronizer latency as well as on the timer compare. The bench therefore sweeps the busy-rise and busy-fall times over several cycles on each side of the start limit and the short limit. It also probes the long limit with `motor_en` set. Each run starts from a fresh reset, and the expected verdict is computed from the limit minus the synchronizer delay. A second delicate case is the pulse-width boundary of the error filter: one-cycle and two-cycle pulses are applied back to back in `ST_READY`.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        ST_RESET_HELD,
        ST_WAIT_BUSY_HI,
        ST_WAIT_BUSY_LO,
        ST_GUARD,
        ST_READY,
        ST_PARKING,
        ST_FAULT
    } sup_state_t;

    // Cycles spanned by a duration given in microseconds.
    function automatic longint unsigned us_to_cyc(input longint unsigned hz,
                                                  input longint unsigned us);
        return (hz * us) / 64'd1_000_000;
    endfunction

    function automatic longint unsigned max2(input longint unsigned a,
                                             input longint unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sup_sat_timer.sv
module sup_sat_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != TOP) cnt <= cnt + 1'b1;
    end

    // The count holds at its top value instead of wrapping to zero.
    p_timer_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == TOP) |=> (cnt == TOP));
endmodule

// File: rtl/sup_pulse_qual.sv
module sup_pulse_qual #(
    parameter int MIN_HI = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic in,
    output logic hit
);
    localparam int CW = $clog2(MIN_HI + 1);
    localparam logic [CW-1:0] NEED = CW'(MIN_HI - 1);

    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          run <= '0;
        else if (!(en && in)) run <= '0;
        else if (run < NEED)  run <= run + 1'b1;
    end

    assign hit = en && in && (run >= NEED);

    // A qualified pulse needs at least one earlier high cycle.
    p_hit_needs_history_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(en && in));
endmodule

// File: rtl/ctrl_bringup_supervisor.sv
module ctrl_bringup_supervisor
    import sup_pkg::*;
#(
    parameter longint unsigned CLK_HZ       = 100_000_000,
    parameter longint unsigned START_US     = 5_000,
    parameter longint unsigned INIT_US      = 100_000,
    parameter longint unsigned LONG_INIT_MS = 5_000,
    parameter longint unsigned GUARD_US     = 3_000,
    parameter longint unsigned HOLD_US      = 500,
    parameter int              ERR_MIN_HI   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic motor_en,
    input  logic park_warn,
    input  logic ctl_status,
    output logic ctl_rst_n,
    output logic host_ready,
    output logic start_timeout,
    output logic init_timeout,
    output logic err_flag
);
    localparam longint unsigned C_START = us_to_cyc(CLK_HZ, START_US);
    localparam longint unsigned C_INIT  = us_to_cyc(CLK_HZ, INIT_US);
    localparam longint unsigned C_LONG  = us_to_cyc(CLK_HZ, LONG_INIT_MS * 1000);
    localparam longint unsigned C_GUARD = us_to_cyc(CLK_HZ, GUARD_US);
    localparam longint unsigned C_HOLD  = us_to_cyc(CLK_HZ, HOLD_US);
    localparam longint unsigned C_MAX   =
        max2(max2(C_START, C_INIT), max2(C_LONG, max2(C_GUARD, C_HOLD)));
    localparam int TW = $clog2(C_MAX + 2);

    localparam logic [TW-1:0] L_START = TW'(C_START);
    localparam logic [TW-1:0] L_INIT  = TW'(C_INIT);
    localparam logic [TW-1:0] L_LONG  = TW'(C_LONG);
    localparam logic [TW-1:0] L_GUARD = TW'(C_GUARD);
    localparam logic [TW-1:0] L_HOLD  = TW'(C_HOLD);

    // Synchronize the asynchronous status and warning inputs.
    logic status_s, park_s;

    sup_sync #(.W(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({park_warn, ctl_status}),
        .q    ({park_s, status_s})
    );

    sup_state_t    state, state_n;
    logic [TW-1:0] tmr;
    logic [TW-1:0] init_lim;
    logic          tmr_clr;
    logic          start_ok;
    logic          in_init;
    logic          err_hit;

    assign start_ok = start_req && !park_s;
    assign init_lim = motor_en ? L_LONG : L_INIT;
    assign in_init  = (state == ST_WAIT_BUSY_HI) || (state == ST_WAIT_BUSY_LO) ||
                      (state == ST_GUARD)        || (state == ST_READY);

    // The timer runs on from reset release through both busy phases.
    assign tmr_clr = ((state_n != state) && (state_n != ST_WAIT_BUSY_LO)) ||
                     ((state == ST_PARKING) && park_s);

    sup_sat_timer #(.W(TW)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .cnt  (tmr)
    );

    sup_pulse_qual #(.MIN_HI(ERR_MIN_HI)) u_err (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state == ST_READY),
        .in   (status_s),
        .hit  (err_hit)
    );

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_RESET_HELD:
                if (start_ok) state_n = ST_WAIT_BUSY_HI;
            ST_WAIT_BUSY_HI:
                if (park_s)              state_n = ST_PARKING;
                else if (status_s)       state_n = ST_WAIT_BUSY_LO;
                else if (tmr >= L_START) state_n = ST_FAULT;
            ST_WAIT_BUSY_LO:
                if (park_s)               state_n = ST_PARKING;
                else if (!status_s)       state_n = ST_GUARD;
                else if (tmr >= init_lim) state_n = ST_FAULT;
            ST_GUARD:
                if (park_s)              state_n = ST_PARKING;
                else if (tmr >= L_GUARD) state_n = ST_READY;
            ST_READY:
                if (park_s) state_n = ST_PARKING;
            ST_PARKING:
                if (!park_s && tmr >= L_HOLD) state_n = ST_RESET_HELD;
            ST_FAULT:
                if (start_ok) state_n = ST_WAIT_BUSY_HI;
            default:
                state_n = ST_RESET_HELD;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET_HELD;
        else        state <= state_n;
    end

    // Latched flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_timeout <= 1'b0;
            init_timeout  <= 1'b0;
            err_flag      <= 1'b0;
        end else if (state_n == ST_WAIT_BUSY_HI && state != ST_WAIT_BUSY_HI) begin
            start_timeout <= 1'b0;
            init_timeout  <= 1'b0;
            err_flag      <= 1'b0;
        end else begin
            if (state == ST_WAIT_BUSY_HI && state_n == ST_FAULT) start_timeout <= 1'b1;
            if (state == ST_WAIT_BUSY_LO && state_n == ST_FAULT) init_timeout  <= 1'b1;
            if (err_hit)                                         err_flag      <= 1'b1;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        ctl_rst_n  = 1'b1;
        host_ready = 1'b0;
        unique case (state)
            ST_RESET_HELD, ST_FAULT: ctl_rst_n  = 1'b0;
            ST_READY:                host_ready = 1'b1;
            default: ;
        endcase
    end

    p_start_to_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_timeout) |-> $past(state) == ST_WAIT_BUSY_HI);

    p_init_to_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_timeout) |-> $past(state) == ST_WAIT_BUSY_LO);

    p_ready_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> ctl_rst_n);

    p_ready_from_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ready) |-> $past(state) == ST_GUARD);

    p_err_only_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(state) == ST_READY);

    p_park_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARKING && park_s) |=> ctl_rst_n);

    p_park_abandons_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_init && park_s) |=> (state == ST_PARKING));

    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && !start_ok) |=> (state == ST_FAULT && !ctl_rst_n));
endmodule

// File: tb/ctrl_bringup_supervisor_test.sv
module ctrl_bringup_supervisor_test;
    localparam longint unsigned HZ      = 10_000;
    localparam longint unsigned LONG_MS = 300;
    localparam int L_START = int'(HZ * 5000 / 1_000_000);
    localparam int L_INIT  = int'(HZ * 100_000 / 1_000_000);
    localparam int L_LONG  = int'(HZ * LONG_MS * 1000 / 1_000_000);
    localparam int L_GUARD = int'(HZ * 3000 / 1_000_000);
    localparam int L_HOLD  = int'(HZ * 500 / 1_000_000);

    logic clk = 1'b0;
    logic rst_n, start_req, motor_en, park_warn, ctl_status;
    logic ctl_rst_n, host_ready, start_timeout, init_timeout, err_flag;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    ctrl_bringup_supervisor #(.CLK_HZ(HZ), .LONG_INIT_MS(LONG_MS)) uut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .motor_en(motor_en),
        .park_warn(park_warn), .ctl_status(ctl_status), .ctl_rst_n(ctl_rst_n),
        .host_ready(host_ready), .start_timeout(start_timeout),
        .init_timeout(init_timeout), .err_flag(err_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start_req = 1'b0; motor_en = 1'b0;
        park_warn = 1'b0; ctl_status = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // After return the start edge (E0) has passed.
    task automatic go_start();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    // Brings the block to ST_READY with a busy fall after 20 cycles.
    task automatic bring_up();
        go_start();
        ctl_status = 1'b1;
        wait_cyc(20);
        ctl_status = 1'b0;
        wait_cyc(L_GUARD + 10);
    endtask

    initial begin
        wait_cyc(150_000);
        miscompares++;
        $display("FAIL watchdog: actual 0 expected 1 (run ended)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state and idle behaviour
        chk("R1 rst", ctl_rst_n, 0);
        chk("R1 ready", host_ready, 0);
        chk("R1 flags", {start_timeout, init_timeout, err_flag}, 0);
        wait_cyc(10);
        chk("R1 idle rst", ctl_rst_n, 0);
        go_start();
        chk("R1 release", ctl_rst_n, 1);

        // R2 sweep of the busy rise around the start limit
        for (int d = L_START - 4; d <= L_START + 1; d++) begin
            do_reset();
            go_start();
            wait_cyc(d);
            ctl_status = 1'b1;
            wait_cyc(L_START + 8 - d);
            chk($sformatf("R2 start_to d=%0d", d), start_timeout, (d >= L_START - 1) ? 1 : 0);
            chk($sformatf("R2 rst d=%0d", d), ctl_rst_n, (d >= L_START - 1) ? 0 : 1);
        end

        // R3 sweep of the busy fall around the short limit
        for (int k = L_INIT - 4; k <= L_INIT + 1; k++) begin
            do_reset();
            go_start();
            ctl_status = 1'b1;
            wait_cyc(k);
            ctl_status = 1'b0;
            wait_cyc(12);
            chk($sformatf("R3 init_to k=%0d", k), init_timeout, (k >= L_INIT - 1) ? 1 : 0);
            chk($sformatf("R3 rst k=%0d", k), ctl_rst_n, (k >= L_INIT - 1) ? 0 : 1);
        end

        // R4 long limit with motor control
        for (int t = 0; t < 3; t++) begin
            automatic int k = (t == 0) ? L_INIT + 50 : (t == 1) ? L_LONG - 2 : L_LONG - 1;
            do_reset();
            motor_en = 1'b1;
            go_start();
            ctl_status = 1'b1;
            wait_cyc(k);
            ctl_status = 1'b0;
            wait_cyc(12);
            chk($sformatf("R4 init_to k=%0d", k), init_timeout, (t == 2) ? 1 : 0);
        end

        // R5 guard gap and R7 pulses during the gap
        do_reset();
        go_start();
        ctl_status = 1'b1;
        wait_cyc(100);
        ctl_status = 1'b0;
        chk("R5 not ready while busy", host_ready, 0);
        wait_cyc(5);
        ctl_status = 1'b1;
        wait_cyc(3);
        ctl_status = 1'b0;
        wait_cyc(L_GUARD + 3 - 8);
        chk("R5 gap edge low", host_ready, 0);
        @(negedge clk);
        chk("R5 ready rises", host_ready, 1);
        wait_cyc(5);
        chk("R7 no err from guard pulse", err_flag, 0);

        // R6 pulse-width filter and stickiness
        ctl_status = 1'b1;
        @(negedge clk);
        ctl_status = 1'b0;
        wait_cyc(8);
        chk("R6 one-cycle ignored", err_flag, 0);
        ctl_status = 1'b1;
        wait_cyc(2);
        ctl_status = 1'b0;
        wait_cyc(8);
        chk("R6 two-cycle flagged", err_flag, 1);
        wait_cyc(30);
        chk("R6 sticky", err_flag, 1);

        // R8 park from ready
        park_warn = 1'b1;
        wait_cyc(2);
        chk("R8 ready before sync", host_ready, 1);
        @(negedge clk);
        chk("R8 ready dropped", host_ready, 0);
        wait_cyc(20);
        chk("R8 held while warned", ctl_rst_n, 1);
        park_warn = 1'b0;
        wait_cyc(L_HOLD + 2);
        chk("R8 hold not over", ctl_rst_n, 1);
        @(negedge clk);
        chk("R8 reset after hold", ctl_rst_n, 0);
        chk("R6 flag kept until start", err_flag, 1);
        go_start();
        chk("R6 cleared by start", err_flag, 0);

        // R9 park abandons initialization
        do_reset();
        go_start();
        park_warn = 1'b1;
        wait_cyc(L_START + 10);
        chk("R9 no start timeout", start_timeout, 0);
        chk("R9 released while parked", ctl_rst_n, 1);
        chk("R9 not ready", host_ready, 0);
        park_warn = 1'b0;
        wait_cyc(L_HOLD + 2);
        chk("R9 hold not over", ctl_rst_n, 1);
        @(negedge clk);
        chk("R9 reset after hold", ctl_rst_n, 0);

        // R10 fault exit rules
        do_reset();
        go_start();
        wait_cyc(L_START + 5);
        chk("R10 in fault", ctl_rst_n, 0);
        park_warn = 1'b1;
        wait_cyc(5);
        chk("R10 park ignored", ctl_rst_n, 0);
        go_start();
        wait_cyc(2);
        chk("R10 start under warning ignored", ctl_rst_n, 0);
        chk("R10 flag kept", start_timeout, 1);
        park_warn = 1'b0;
        wait_cyc(4);
        go_start();
        chk("R10 start leaves fault", ctl_rst_n, 1);
        chk("R10 flag cleared", start_timeout, 0);

        // R5 full bring-up once more with a different busy length
        do_reset();
        bring_up();
        chk("R5 ready after bring-up", host_ready, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule